// File: doc/BRIEF.md
# Output Short Integrating Detector

This block watches the gate drive of a quasi-resonant converter and decides that the output is shorted when off-times stay too long. It counts how many clock cycles the drive stays low. When one low interval runs past a threshold, the block launches a timed pulse. While that pulse is active it charges an up/down integrator, and while it is not active it drains it. Charging runs a fixed ratio faster than draining. Isolated long off-times therefore fade away, while a steady run of them fills the integrator to its limit.

When the limit is reached the block raises an output-short fault. The fault clears the integrator, stops detection, and holds for a fixed recovery time. After that the block releases the fault so the switching sequencer can try again. A configuration input switches the whole detector off. All times are given as clock-cycle parameters, so the defaults are scaled versions of the real microsecond and millisecond values.

Top module: `short_integ_det`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fault` and `short_pulse` are low.
- R2: The detector must be enabled and not in fault. If `drv` is sampled low on more than OFF_CYC consecutive clock edges, `short_pulse` rises at the edge that samples the (OFF_CYC+1)-th low. Exactly OFF_CYC low samples launch nothing. A long low interval launches only one pulse. A high sample on `drv` restarts the off-time count.
- R3: A pulse that is not retriggered and not cut off by a fault stays high for exactly PULSE_CYC cycles.
- R4: A new long off-time that occurs while a pulse is running reloads the pulse to PULSE_CYC cycles, counted from the new trigger edge. It does not add to the time that remains.
- R5: Each edge that sees the pulse active adds RATIO to the integrator. Each edge that sees it inactive subtracts 1. The limit is FILL_CYC*RATIO. A pulse that stays high without a break, starting from an empty integrator, raises `fault` FILL_CYC edges after the pulse rose.
- R6: Gaps between pulses delay the fault. After one full pulse, then a gap of G discharge edges, then a continuous pulse, the fault rises ceil((FILL_CYC*RATIO - (PULSE_CYC*RATIO - G))/RATIO) edges after the second pulse rises, for G < PULSE_CYC*RATIO.
- R7: The integrator saturates at zero when discharging. After a long gap, the fault timing is the same as from empty.
- R8: When `fault` rises, `short_pulse` drops at the same edge and the integrator is cleared. `fault` then stays high for exactly RECOVER_CYC cycles. During that time no pulse is launched.
- R9: While `det_en` is low, `short_pulse` and `fault` are low. Driving `det_en` low clears an active fault at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | High enables detection; low holds the whole detector cleared |
| drv | input | 1 | Gate drive level; low marks the off-time |
| short_pulse | output | 1 | Integration pulse, high while the integrator charges |
| fault | output | 1 | Output-short fault, held for the recovery time |

## Verification
The hardest situation to reach is a fault whose timing depends on what the integrator already holds. The integrator is never visible at the ports. The stimulus first charges it with one isolated pulse and then leaves a measured gap of drive-high cycles. It then starts a retriggering train of off-times. The exact fault edge shows the remaining charge, and a long gap shows whether the integrator stops at zero. Retriggering is exposed by two close long off-times whose pulse ends 150 cycles after the second trigger.

// File: rtl/short_integ_det.sv
module short_integ_det #(
  parameter int OFF_CYC     = 50,
  parameter int PULSE_CYC   = 150,
  parameter int RATIO       = 20,
  parameter int FILL_CYC    = 400,
  parameter int RECOVER_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_en,
  input  logic drv,
  output logic short_pulse,
  output logic fault
);

  localparam int INT_MAX = FILL_CYC * RATIO;
  localparam int OW = $clog2(OFF_CYC + 2);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int AW = $clog2(INT_MAX + RATIO + 1);
  localparam int RW = $clog2(RECOVER_CYC + 1);

  localparam logic [OW-1:0] OFF_HIT = OW'(OFF_CYC);
  localparam logic [OW-1:0] OFF_SAT = OW'(OFF_CYC + 1);
  localparam logic [PW-1:0] PUL_LD  = PW'(PULSE_CYC);
  localparam logic [AW-1:0] STEP_UP = AW'(RATIO);
  localparam logic [AW-1:0] LIMIT   = AW'(INT_MAX);
  localparam logic [RW-1:0] REC_LD  = RW'(RECOVER_CYC - 1);

  logic [OW-1:0] off_cnt;
  logic [PW-1:0] pul_cnt;
  logic [AW-1:0] acc;
  logic [RW-1:0] rec_cnt;
  logic          fault_q;

  logic          pulse_on, hit, trip;
  logic [AW-1:0] acc_up;

  assign pulse_on = (pul_cnt != '0);
  assign hit      = !drv && (off_cnt == OFF_HIT);
  assign acc_up   = acc + STEP_UP;
  assign trip     = pulse_on && (acc_up >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt <= '0;
      pul_cnt <= '0;
      acc     <= '0;
      rec_cnt <= '0;
      fault_q <= 1'b0;
    end else if (!det_en) begin
      off_cnt <= '0;
      pul_cnt <= '0;
      acc     <= '0;
      rec_cnt <= '0;
      fault_q <= 1'b0;
    end else if (fault_q) begin
      off_cnt <= '0;
      pul_cnt <= '0;
      acc     <= '0;
      if (rec_cnt == '0) fault_q <= 1'b0;
      else               rec_cnt <= rec_cnt - 1'b1;
    end else if (trip) begin
      off_cnt <= '0;
      pul_cnt <= '0;
      acc     <= '0;
      rec_cnt <= REC_LD;
      fault_q <= 1'b1;
    end else begin
      if (drv)                    off_cnt <= '0;
      else if (off_cnt != OFF_SAT) off_cnt <= off_cnt + 1'b1;

      if (hit)           pul_cnt <= PUL_LD;
      else if (pulse_on) pul_cnt <= pul_cnt - 1'b1;

      if (pulse_on)       acc <= acc_up;
      else if (acc != '0) acc <= acc - 1'b1;
    end
  end

  assign short_pulse = pulse_on;
  assign fault       = fault_q;

endmodule

// File: rtl/short_integ_det_chk.sv
module short_integ_det_chk (
  input logic clk,
  input logic rst_n,
  input logic det_en,
  input logic drv,
  input logic short_pulse,
  input logic fault
);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (!fault && !short_pulse)); // R9

  AST_NO_PULSE_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !short_pulse); // R8

  AST_PULSE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_pulse) |-> (!$past(drv) && $past(det_en))); // R2

  AST_FAULT_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(short_pulse)); // R5

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault) && det_en) |=> fault); // R8

endmodule

bind short_integ_det short_integ_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .drv(drv),
  .short_pulse(short_pulse), .fault(fault)
);

// File: tb/short_integ_det_bench.sv
`timescale 1ns/1ps
module short_integ_det_bench;

  localparam int OFF_CYC = 50, PULSE_CYC = 150, RATIO = 20;
  localparam int FILL_CYC = 400, RECOVER_CYC = 2000;

  typedef struct {
    bit    is_fault;
    bit    val;
    int    cyc;
    string req;
  } ev_t;

  logic clk = 0, rst_n = 0, det_en = 1, drv = 1;
  logic short_pulse, fault;
  int   cyc = 0, checks = 0, errs = 0;
  bit   mon_on = 0, prev_p = 0, prev_f = 0;
  string cur_req = "R1";
  ev_t  expq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  short_integ_det #(.OFF_CYC(OFF_CYC), .PULSE_CYC(PULSE_CYC), .RATIO(RATIO),
    .FILL_CYC(FILL_CYC), .RECOVER_CYC(RECOVER_CYC)) u_short_integ_det (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .drv(drv),
    .short_pulse(short_pulse), .fault(fault));

  task automatic expect_ev(bit f, bit v, int c, string r);
    ev_t e;
    e.is_fault = f; e.val = v; e.cyc = c; e.req = r;
    expq.push_back(e);
  endtask

  task automatic got_ev(bit f, bit v);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      errs++;
      $display("FAIL %s: unexpected %s=%0d at cycle %0d, expected no event",
               cur_req, f ? "fault" : "short_pulse", v, cyc);
    end else begin
      e = expq.pop_front();
      if (e.is_fault != f || e.val != v || e.cyc != cyc) begin
        errs++;
        $display("FAIL %s: got %s=%0d at cycle %0d, expected %s=%0d at cycle %0d",
                 e.req, f ? "fault" : "short_pulse", v, cyc,
                 e.is_fault ? "fault" : "short_pulse", e.val, e.cyc);
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (short_pulse !== prev_p) begin prev_p = short_pulse; got_ev(0, short_pulse); end
      if (fault !== prev_f)       begin prev_f = fault;       got_ev(1, fault);       end
    end
  end

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_run(int n);
    drv = 0; waitn(n); drv = 1;
  endtask

  task automatic train(int periods);
    for (int i = 0; i < periods; i++) begin
      drv = 0; waitn(60); drv = 1; waitn(1);
    end
  endtask

  task automatic flush();
    det_en = 0; waitn(1); det_en = 1; waitn(1);
  endtask

  task automatic drain_check(string r);
    checks++;
    if (expq.size() != 0) begin
      errs++;
      $display("FAIL %s: %0d expected events missing, expected 0", r, expq.size());
      expq.delete();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin : driver
    int n0, m0;
    waitn(3);
    checks++;
    if (short_pulse !== 0 || fault !== 0) begin
      errs++;
      $display("FAIL R1: pulse=%b fault=%b in reset, expected 0 0", short_pulse, fault);
    end
    rst_n = 1;
    waitn(1);
    checks++;
    if (short_pulse !== 0 || fault !== 0) begin
      errs++;
      $display("FAIL R1: pulse=%b fault=%b after reset, expected 0 0", short_pulse, fault);
    end
    mon_on = 1;

    // R2 boundary: exactly OFF_CYC lows -> nothing
    cur_req = "R2"; low_run(OFF_CYC); waitn(100);
    // R2/R3: OFF_CYC+1 lows -> one pulse of PULSE_CYC
    n0 = cyc + 1;
    expect_ev(0, 1, n0 + 50, "R2");
    expect_ev(0, 0, n0 + 200, "R3");
    cur_req = "R3"; low_run(OFF_CYC + 1); waitn(300); drain_check("R3"); flush();

    // R4 retrigger: second trigger reloads
    cur_req = "R4"; n0 = cyc + 1;
    expect_ev(0, 1, n0 + 50, "R4");
    expect_ev(0, 0, n0 + 261, "R4");
    low_run(60); waitn(1); low_run(60); waitn(400); drain_check("R4"); flush();

    // R5/R8 continuous train -> fault after FILL_CYC, held RECOVER_CYC
    cur_req = "R5"; n0 = cyc + 1;
    expect_ev(0, 1, n0 + 50, "R5");
    expect_ev(0, 0, n0 + 450, "R8");
    expect_ev(1, 1, n0 + 450, "R5");
    expect_ev(1, 0, n0 + 2450, "R8");
    train(8); cur_req = "R8"; waitn(2100); drain_check("R8");

    // R6 gap of 1000 after one full pulse: fault 300 edges after second rise
    cur_req = "R6"; n0 = cyc + 1; m0 = n0 + 1150;
    expect_ev(0, 1, n0 + 50, "R6");
    expect_ev(0, 0, n0 + 200, "R6");
    expect_ev(0, 1, m0 + 50, "R6");
    expect_ev(0, 0, m0 + 350, "R6");
    expect_ev(1, 1, m0 + 350, "R6");
    expect_ev(1, 0, m0 + 2350, "R6");
    low_run(60); waitn(1090); train(8); waitn(2100); drain_check("R6");

    // R7 gap of 5000: integrator floored at zero -> full FILL_CYC
    cur_req = "R7"; n0 = cyc + 1; m0 = n0 + 5150;
    expect_ev(0, 1, n0 + 50, "R7");
    expect_ev(0, 0, n0 + 200, "R7");
    expect_ev(0, 1, m0 + 50, "R7");
    expect_ev(0, 0, m0 + 450, "R7");
    expect_ev(1, 1, m0 + 450, "R7");
    expect_ev(1, 0, m0 + 2450, "R7");
    low_run(60); waitn(5090); train(8); waitn(2100); drain_check("R7");

    // R9 disabled: no pulse or fault at all
    cur_req = "R9"; det_en = 0; waitn(1);
    train(8); waitn(200); det_en = 1; waitn(2); drain_check("R9");

    // R9 disable clears an active fault
    n0 = cyc + 1;
    expect_ev(0, 1, n0 + 50, "R9");
    expect_ev(0, 0, n0 + 450, "R9");
    expect_ev(1, 1, n0 + 450, "R9");
    train(8);
    expect_ev(1, 0, cyc + 1, "R9");
    det_en = 0; waitn(3); det_en = 1; waitn(5); drain_check("R9");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule